// File: doc/BRIEF.md
# Bridge Configuration Register File

This block keeps the type-1 configuration header of a PCI-to-PCI bridge. It holds the following fields:

- the three bus numbers and the secondary latency timer;
- the I/O, memory and prefetchable window base/limit fields, with their upper extensions;
- the command register and bridge control;
- the fixed identity and status fields.

A configuration agent reaches the header through a dword-indexed port with byte enables. Reads are combinational, so the addressed dword appears on the read bus in the same cycle with no wait states. Writes take effect on the rising clock edge.

Two events are brought out for the forwarding logic next to the block. A remap strobe tells the window decoders to reload when a write touches any byte that shapes the windows or their enables. A secondary bus reset pulse fires once when software raises the bus-reset control bit. A separate forwarding-off command closes every window in one cycle: each base is made higher than its limit.

Top module: `p2p_cfg_regs`

## Requirements
- R1: After reset, dword 6 reads 0: primary bus in bits 7:0, secondary bus in 15:8, subordinate bus in 23:16 and secondary latency timer in 31:24.
- R2: After reset, the writable bits of every window register and of bridge control read 0. Dword 7 reads 0x00A00101, dword 8 reads 0, dword 9 reads 0x00010001, dwords 10, 11 and 12 read 0, and dword 15 reads 0.
- R3: A one-cycle `fwd_off` closes every window. It sets all range bits of each base (dword 7 bits 7:4; dword 8 and dword 9 bits 15:4). It clears all range bits of each limit (dword 7 bits 15:12; dword 8 and dword 9 bits 31:20). It zeroes dwords 10 and 11 and leaves dword 12 unchanged. No remap strobe results from the command alone.
- R4: When `fwd_off` and a write to dword 7, 8, 9, 10 or 11 share a cycle, the forwarding-off result wins for that dword.
- R5: `sec_bus_rst` is high for exactly one cycle, in the cycle after the clock edge on which dword 15 bit 22 (bridge control bit 6) goes from 0 to 1.
- R6: Writing 1 to dword 15 bit 22 while it is already 1, or writing it to 0, produces no `sec_bus_rst`.
- R7: `remap_stb` is high in the cycle after a write edge if any enabled byte has one of these byte offsets: 4–5 (command), 28–29 (I/O base/limit), 32–51 (memory base through I/O limit upper half), or 62–63 (bridge control).
- R8: A write whose enabled bytes all lie outside those offsets gives no `remap_stb`. Examples are bus numbers, the status halves of dwords 1 and 7, and interrupt bytes 60–61.
- R9: Dword 0 reads {DEVICE_ID, VENDOR_ID}. Dword 2 reads {0x060400, REV_ID}. Dword 3 bits 23:16 read 0x01, with bit 23 equal to MULTI_FN.
- R10: The primary status (dword 1 bits 31:16) and secondary status (dword 7 bits 31:16) read 0x00A0, which sets the 66 MHz and fast back-to-back bits. Writes to them have no effect.
- R11: A write changes only bytes whose enable is set, and within those only the writable bits. The writable bits are command bits 10:0 except bit 5, dword 6 entirely, and the range bits of dwords 7–9. They also include dwords 10–12 entirely and bridge control bits 11:0 (dword 15 bits 27:16). All other bits read their fixed value.
- R12: `cfg_rdata` shows the dword selected by `cfg_dw` in the same cycle, and a completed write is visible there right after its clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Write strobe for the selected dword |
| cfg_dw | input | 4 | Dword index into the 64-byte header |
| cfg_be | input | 4 | Byte enables for the write |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data of the selected dword, combinational |
| fwd_off | input | 1 | Close all forwarding windows |
| remap_stb | output | 1 | One-cycle pulse after a window-affecting write |
| sec_bus_rst | output | 1 | One-cycle secondary bus reset pulse |

## Verification
Read data is combinational, so the bench moves `cfg_dw` and samples `cfg_rdata` a little later in the same low clock phase. Both `remap_stb` and `sec_bus_rst` are due in the cycle that follows the rising edge that took the write or command. The bench therefore drives on a falling edge, lets one rising edge pass, and samples at the next falling edge. For the single-cycle properties it samples once more a full cycle later. Register state after `fwd_off` and after reset is read back through the same port, at the same one-edge distance.

// File: rtl/p2p_cfg_pkg.sv
package p2p_cfg_pkg;

  localparam int DW_W   = 32;
  localparam int BE_W   = DW_W / 8;
  localparam int IDX_W  = 4;
  localparam int N_DW   = 1 << IDX_W;

  localparam int IDX_ID   = 0;
  localparam int IDX_CMD  = 1;
  localparam int IDX_CLS  = 2;
  localparam int IDX_HDR  = 3;
  localparam int IDX_BUS  = 6;
  localparam int IDX_IO   = 7;
  localparam int IDX_MEM  = 8;
  localparam int IDX_PREF = 9;
  localparam int IDX_PBU  = 10;
  localparam int IDX_PLU  = 11;
  localparam int IDX_IOU  = 12;
  localparam int IDX_CTL  = 15;

  localparam int CTL_BUSRST_BIT = 16 + 6;
  localparam logic [15:0] STAT_CAPS = 16'h00A0;

  // bits software may change, per dword
  function automatic logic [DW_W-1:0] wmask_of(input int idx);
    case (idx)
      IDX_CMD:  return 32'h0000_07DF;
      IDX_BUS:  return 32'hFFFF_FFFF;
      IDX_IO:   return 32'h0000_F0F0;
      IDX_MEM:  return 32'hFFF0_FFF0;
      IDX_PREF: return 32'hFFF0_FFF0;
      IDX_PBU:  return 32'hFFFF_FFFF;
      IDX_PLU:  return 32'hFFFF_FFFF;
      IDX_IOU:  return 32'hFFFF_FFFF;
      IDX_CTL:  return 32'h0FFF_0000;
      default:  return '0;
    endcase
  endfunction

  // bits forced to 1 by the forwarding-off command (base range bits)
  function automatic logic [DW_W-1:0] fwd_set_of(input int idx);
    case (idx)
      IDX_IO:   return 32'h0000_00F0;
      IDX_MEM:  return 32'h0000_FFF0;
      IDX_PREF: return 32'h0000_FFF0;
      default:  return '0;
    endcase
  endfunction

  // bits forced to 0 by the forwarding-off command (limit range bits, uppers)
  function automatic logic [DW_W-1:0] fwd_clr_of(input int idx);
    case (idx)
      IDX_IO:   return 32'h0000_F000;
      IDX_MEM:  return 32'hFFF0_0000;
      IDX_PREF: return 32'hFFF0_0000;
      IDX_PBU:  return 32'hFFFF_FFFF;
      IDX_PLU:  return 32'hFFFF_FFFF;
      default:  return '0;
    endcase
  endfunction

  // fixed value of the non-writable bits
  function automatic logic [DW_W-1:0] ro_value(input int idx,
                                               input logic [15:0] ven,
                                               input logic [15:0] dev,
                                               input logic [7:0]  rev,
                                               input logic        mf);
    case (idx)
      IDX_ID:   return {dev, ven};
      IDX_CMD:  return {STAT_CAPS, 16'h0000};
      IDX_CLS:  return {24'h060400, rev};
      IDX_HDR:  return {8'h00, mf, 7'h01, 16'h0000};
      IDX_IO:   return {STAT_CAPS, 16'h0101};
      IDX_PREF: return 32'h0001_0001;
      default:  return '0;
    endcase
  endfunction

  // byte-lane merge restricted to writable bits
  function automatic logic [DW_W-1:0] merge_bytes(input logic [DW_W-1:0] old,
                                                  input logic [DW_W-1:0] wd,
                                                  input logic [BE_W-1:0] be,
                                                  input logic [DW_W-1:0] mask);
    logic [DW_W-1:0] r;
    r = old;
    for (int b = 0; b < BE_W; b++) begin
      if (be[b]) begin
        r[b*8 +: 8] = (old[b*8 +: 8] & ~mask[b*8 +: 8]) | (wd[b*8 +: 8] & mask[b*8 +: 8]);
      end
    end
    return r;
  endfunction

  // header byte offsets whose change alters forwarding
  function automatic logic byte_affects_windows(input int unsigned off);
    return (off == 4)  || (off == 5)  ||
           (off == 28) || (off == 29) ||
           ((off >= 32) && (off <= 51)) ||
           (off == 62) || (off == 63);
  endfunction

  function automatic logic write_hits_windows(input logic [IDX_W-1:0] idx,
                                              input logic [BE_W-1:0]  be);
    logic hit;
    hit = 1'b0;
    for (int b = 0; b < BE_W; b++) begin
      if (be[b] && byte_affects_windows(int'(idx) * BE_W + b)) hit = 1'b1;
    end
    return hit;
  endfunction

endpackage

// File: rtl/p2p_cfg_dword.sv
module p2p_cfg_dword
  import p2p_cfg_pkg::*;
#(
  parameter logic [DW_W-1:0] WMASK = '0,
  parameter logic [DW_W-1:0] FSET  = '0,
  parameter logic [DW_W-1:0] FCLR  = '0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [BE_W-1:0] be,
  input  logic [DW_W-1:0] wdata,
  input  logic            fwd,
  output logic [DW_W-1:0] q
);
  localparam bit HAS_FWD = ((FSET | FCLR) != '0);

  logic [DW_W-1:0] nxt;

  always_comb begin
    nxt = q;
    if (wr_en) nxt = merge_bytes(q, wdata, be, WMASK);
    if (HAS_FWD && fwd) nxt = (q | FSET) & ~FCLR;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= nxt & WMASK;
  end
endmodule

// File: rtl/p2p_remap_detect.sv
module p2p_remap_detect
  import p2p_cfg_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [IDX_W-1:0] idx,
  input  logic [BE_W-1:0]  be,
  output logic             stb
);
  logic hit;
  assign hit = we && write_hits_windows(idx, be);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stb <= 1'b0;
    else        stb <= hit;
  end
endmodule

// File: rtl/p2p_bus_rst_edge.sv
module p2p_bus_rst_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic ctl_bit,
  output logic pulse
);
  logic prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev <= 1'b0;
    else        prev <= ctl_bit;
  end

  assign pulse = ctl_bit & ~prev;
endmodule

// File: rtl/p2p_cfg_regs.sv
module p2p_cfg_regs
  import p2p_cfg_pkg::*;
#(
  parameter logic [15:0] VENDOR_ID = 16'hABCD,
  parameter logic [15:0] DEVICE_ID = 16'h0B17,
  parameter logic [7:0]  REV_ID    = 8'h02,
  parameter bit          MULTI_FN  = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [IDX_W-1:0] cfg_dw,
  input  logic [BE_W-1:0]  cfg_be,
  input  logic [DW_W-1:0]  cfg_wdata,
  output logic [DW_W-1:0]  cfg_rdata,
  input  logic             fwd_off,
  output logic             remap_stb,
  output logic             sec_bus_rst
);
  logic [DW_W-1:0] view [N_DW];

  for (genvar g = 0; g < N_DW; g++) begin : g_dw
    localparam logic [DW_W-1:0] WM = wmask_of(g);
    localparam logic [DW_W-1:0] RO = ro_value(g, VENDOR_ID, DEVICE_ID, REV_ID, MULTI_FN);
    if (WM != '0) begin : g_rw
      logic [DW_W-1:0] stor;
      p2p_cfg_dword #(
        .WMASK (WM),
        .FSET  (fwd_set_of(g)),
        .FCLR  (fwd_clr_of(g))
      ) u_reg (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (cfg_we && (cfg_dw == IDX_W'(g))),
        .be    (cfg_be),
        .wdata (cfg_wdata),
        .fwd   (fwd_off),
        .q     (stor)
      );
      assign view[g] = (stor & WM) | (RO & ~WM);
    end else begin : g_ro
      assign view[g] = RO;
    end
  end

  assign cfg_rdata = view[cfg_dw];

  // named events for the checker
  logic        busrst_bit;
  logic [11:0] mem_lim_rng;
  assign busrst_bit  = view[IDX_CTL][CTL_BUSRST_BIT];
  assign mem_lim_rng = view[IDX_MEM][31:20];

  p2p_remap_detect u_remap (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (cfg_we),
    .idx   (cfg_dw),
    .be    (cfg_be),
    .stb   (remap_stb)
  );

  p2p_bus_rst_edge u_sbr (
    .clk     (clk),
    .rst_n   (rst_n),
    .ctl_bit (busrst_bit),
    .pulse   (sec_bus_rst)
  );
endmodule

// File: rtl/p2p_cfg_chk.sv
module p2p_cfg_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cfg_we,
  input logic [3:0]  cfg_dw,
  input logic        fwd_off,
  input logic        remap_stb,
  input logic        sec_bus_rst,
  input logic        busrst_bit,
  input logic [11:0] mem_lim_rng
);
  // R5
  sec_pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sec_bus_rst |=> !sec_bus_rst);

  // R5
  sec_needs_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sec_bus_rst |-> busrst_bit);

  // R6
  sec_held_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busrst_bit && $past(busrst_bit)) |-> !sec_bus_rst);

  // R7
  remap_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    remap_stb |-> $past(cfg_we));

  // R8
  remap_bus_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cfg_we && (cfg_dw == 4'd6)) |-> !remap_stb);

  // R3
  fwd_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(fwd_off) |-> (mem_lim_rng == 12'h000));
endmodule

bind p2p_cfg_regs p2p_cfg_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cfg_we      (cfg_we),
  .cfg_dw      (cfg_dw),
  .fwd_off     (fwd_off),
  .remap_stb   (remap_stb),
  .sec_bus_rst (sec_bus_rst),
  .busrst_bit  (busrst_bit),
  .mem_lim_rng (mem_lim_rng)
);

// File: tb/sim_p2p_cfg_regs.sv
module sim_p2p_cfg_regs;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [3:0]  cfg_dw = 4'd0;
  logic [3:0]  cfg_be = 4'd0;
  logic [31:0] cfg_wdata = 32'd0;
  logic [31:0] cfg_rdata;
  logic        fwd_off = 1'b0;
  logic        remap_stb;
  logic        sec_bus_rst;

  int n_chk = 0;
  int n_bad = 0;
  logic got_remap, got_sec;

  always #4 clk = ~clk;

  p2p_cfg_regs u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_dw(cfg_dw), .cfg_be(cfg_be),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .fwd_off(fwd_off),
    .remap_stb(remap_stb), .sec_bus_rst(sec_bus_rst)
  );

  localparam int NV = 15;
  // dword, byte enables, write data, expected read, expected remap
  localparam logic [3:0]  V_DW [NV] = '{4'd6, 4'd6, 4'd1, 4'd1, 4'd7, 4'd7, 4'd8, 4'd9,
                                        4'd10, 4'd12, 4'd15, 4'd15, 4'd3, 4'd0, 4'd1};
  localparam logic [3:0]  V_BE [NV] = '{4'hF, 4'h2, 4'h3, 4'hC, 4'h3, 4'hC, 4'hF, 4'hF,
                                        4'h8, 4'h4, 4'h3, 4'h4, 4'hF, 4'hF, 4'h1};
  localparam logic [31:0] V_WD [NV] = '{32'h4030_2010, 32'hFFFF_AAFF, 32'hFFFF_FFFF, 32'h0000_0000,
                                        32'h1234_5678, 32'hFFFF_FFFF, 32'hABCD_1234, 32'hFFFF_FFFF,
                                        32'h8900_0000, 32'h00CC_0000, 32'hFFFF_FFFF, 32'h0001_0000,
                                        32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0000_0000};
  localparam logic [31:0] V_RD [NV] = '{32'h4030_2010, 32'h4030_AA10, 32'h00A0_07DF, 32'h00A0_07DF,
                                        32'h00A0_5171, 32'h00A0_5171, 32'hABC0_1230, 32'hFFF1_FFF1,
                                        32'h8900_0000, 32'h00CC_0000, 32'h0000_0000, 32'h0001_0000,
                                        32'h0001_0000, 32'h0B17_ABCD, 32'h00A0_0700};
  localparam logic        V_RM [NV] = '{1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1,
                                        1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1};
  localparam string       V_RQ [NV] = '{"R11", "R11", "R7", "R10", "R7", "R10", "R7", "R7",
                                        "R7", "R7", "R8", "R7", "R9", "R9", "R7"};

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  // called just after a falling edge
  task automatic rd_chk(input string req, input logic [3:0] idx, input logic [31:0] exp);
    cfg_dw = idx;
    #1;
    chk(req, cfg_rdata, exp);
  endtask

  // drive on a falling edge, one rising edge, sample at the next falling edge
  task automatic wr(input logic [3:0] idx, input logic [3:0] be, input logic [31:0] wd,
                    input logic fwd);
    cfg_we = 1'b1; cfg_dw = idx; cfg_be = be; cfg_wdata = wd; fwd_off = fwd;
    @(posedge clk); @(negedge clk);
    got_remap = remap_stb; got_sec = sec_bus_rst;
    cfg_we = 1'b0; fwd_off = 1'b0; cfg_be = 4'h0;
  endtask

  task automatic fwd_cmd();
    fwd_off = 1'b1;
    @(posedge clk); @(negedge clk);
    got_remap = remap_stb; got_sec = sec_bus_rst;
    fwd_off = 1'b0;
  endtask

  task automatic idle_chk_sec(input string req);
    @(posedge clk); @(negedge clk);
    chk(req, {31'd0, sec_bus_rst}, 32'd0);
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(8 * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // reset state R1 R2 R9 R10
    rd_chk("R1", 4'd6, 32'h0);
    rd_chk("R2", 4'd7, 32'h00A0_0101);
    rd_chk("R2", 4'd8, 32'h0);
    rd_chk("R2", 4'd9, 32'h0001_0001);
    rd_chk("R2", 4'd10, 32'h0);
    rd_chk("R2", 4'd11, 32'h0);
    rd_chk("R2", 4'd12, 32'h0);
    rd_chk("R2", 4'd15, 32'h0);
    rd_chk("R9", 4'd2, 32'h0604_0002);
    rd_chk("R9", 4'd3, 32'h0001_0000);
    rd_chk("R10", 4'd1, 32'h00A0_0000);
    chk("R8", {30'd0, remap_stb, sec_bus_rst}, 32'd0);

    // vector walk R7 R8 R9 R10 R11 R12
    for (int i = 0; i < NV; i++) begin
      wr(V_DW[i], V_BE[i], V_WD[i], 1'b0);
      chk(V_RQ[i], {31'd0, got_remap}, {31'd0, V_RM[i]});
      rd_chk("R12", V_DW[i], V_RD[i]);
    end

    // R5: 0->1 of bridge control bit 6
    wr(4'd15, 4'h4, 32'h0041_0000, 1'b0);
    chk("R5", {31'd0, got_sec}, 32'd1);
    chk("R7", {31'd0, got_remap}, 32'd1);
    idle_chk_sec("R5");
    // R6: bit held at 1
    wr(4'd15, 4'h4, 32'h0041_0000, 1'b0);
    chk("R6", {31'd0, got_sec}, 32'd0);
    idle_chk_sec("R6");
    wr(4'd15, 4'h4, 32'h0001_0000, 1'b0);
    chk("R6", {31'd0, got_sec}, 32'd0);
    wr(4'd15, 4'h4, 32'h0041_0000, 1'b0);
    chk("R5", {31'd0, got_sec}, 32'd1);
    rd_chk("R11", 4'd15, 32'h0041_0000);

    // R3: forwarding off
    fwd_cmd();
    chk("R3", {31'd0, got_remap}, 32'd0);
    rd_chk("R3", 4'd7, 32'h00A0_01F1);
    rd_chk("R3", 4'd8, 32'h0000_FFF0);
    rd_chk("R3", 4'd9, 32'h0001_FFF1);
    rd_chk("R3", 4'd10, 32'h0);
    rd_chk("R3", 4'd11, 32'h0);
    rd_chk("R3", 4'd12, 32'h00CC_0000);

    // R4: command wins over a same-cycle write
    wr(4'd8, 4'hF, 32'h5555_5555, 1'b1);
    chk("R7", {31'd0, got_remap}, 32'd1);
    rd_chk("R4", 4'd8, 32'h0000_FFF0);
    wr(4'd11, 4'hF, 32'h1234_5678, 1'b1);
    rd_chk("R4", 4'd11, 32'h0);

    // R8: interrupt bytes and status halves
    wr(4'd7, 4'h8, 32'hFF00_0000, 1'b0);
    chk("R8", {31'd0, got_remap}, 32'd0);
    wr(4'd15, 4'h1, 32'h0000_00FF, 1'b0);
    chk("R8", {31'd0, got_remap}, 32'd0);

    // R1 R2: reset during operation
    rst_n = 1'b0;
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R2", {31'd0, sec_bus_rst}, 32'd0);
    rd_chk("R1", 4'd6, 32'h0);
    rd_chk("R2", 4'd12, 32'h0);
    rd_chk("R2", 4'd15, 32'h0);
    rd_chk("R2", 4'd9, 32'h0001_0001);

    finish_run();
  end
endmodule